// File: doc/BRIEF.md
# Two-Port Shared Memory Contention Arbiter

This block is a clocked model of the contention logic in front of a memory that two independent agents, called left and right, can access at once. Each side has an active-low select, an active-low write strobe, an active-low output enable, a word address, and separate active-low enables for the high byte lane and the low byte lane. When both sides select the same word in the same cycle, the arbiter grants one side. It pulls the other side's active-low busy flag low and suppresses that side's access until the conflict clears.

Which side wins depends on which event came last. If the addresses already agreed and one side had already been selected, the side selected earlier wins. If both sides were already selected and then the addresses came to agree, the side whose address did not move wins. A strap input picks master or slave operation. A master arbitrates on its own and drives its busy outputs. A slave never arbitrates: it takes a busy flag per side from an external master and uses that flag only to discard writes. This lets several copies be placed side by side to widen the data path while one copy makes every arbitration decision.

The storage is a plain two-port array with a registered read, written so that block RAM can be inferred. The default address width is 10 (1K words). Setting `ADDR_W` to 13 gives the full 8K-word array. Every access, busy decision and read result is sampled on a rising clock edge and appears on the outputs after that edge.

Top module: `shared_ram_contend`

## Requirements
- R1: In master mode a conflict exists only when both selects are low and the two addresses are equal. Without a conflict both busy outputs are 1 after the edge and both sides access the memory independently.
- R2: A low high-byte enable (`*_ub_n`) enables bits 15:8 and a low low-byte enable (`*_lb_n`) enables bits 7:0, for both writes and reads. On a read, a disabled lane returns 0.
- R3: A side that is selected, with write strobe high and output enable low, returns the addressed word on its read data after the sampling edge. In every other case its read data is 16'h0000.
- R4: This is select-order arbitration. When the addresses are equal, a side that was already selected at that same address in the previous cycle wins over a side that has just become selected.
- R5: This is address-order arbitration. When both sides were selected in the previous cycle, the side whose address is unchanged wins over the side whose address has just moved onto it.
- R6: When neither side qualifies as earlier (for example, both become selected at the same address in the same cycle), the left side wins.
- R7: In master mode the losing side's busy output is 0 after the sampling edge. Its write is discarded and its read data is 0.
- R8: While the conflict persists, the same side keeps the grant. In the first cycle in which the winner deselects or moves to another address, both busy outputs return to 1 and the former loser's access takes effect.
- R9: A side whose select is high performs no access, and its busy output is 1 after the edge.
- R10: In slave mode (strap low), both busy outputs are 1 and no local arbitration happens. A write from a side whose busy input is 0 is discarded, while reads are unaffected by the busy inputs.
- R11: In master mode the busy inputs have no effect.
- R12: Synchronous reset sets both busy outputs to 1 and both read data outputs to 0, and clears any grant.
- R13: In slave mode, a read of a word that the other side writes in the same cycle returns the word's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| master_strap | input | 1 | 1 = master (arbitrates), 0 = slave |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left high-byte enable, active low |
| l_lb_n | input | 1 | Left low-byte enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 2*LANE_W | Left write data |
| l_rdata | output | 2*LANE_W | Left read data |
| l_busy_in_n | input | 1 | Left busy from an external master (slave mode) |
| l_busy_out_n | output | 1 | Left busy flag, active low (master mode) |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right high-byte enable, active low |
| r_lb_n | input | 1 | Right low-byte enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 2*LANE_W | Right write data |
| r_rdata | output | 2*LANE_W | Right read data |
| r_busy_in_n | input | 1 | Right busy from an external master (slave mode) |
| r_busy_out_n | output | 1 | Right busy flag, active low (master mode) |

## Verification
On every cycle, the assertions check that:
- at most one busy flag is low;
- a deselected side, a slave, or a pair of sides with no shared address never shows busy;
- a busy side and a side with output enable high return zero data;
- reset clears the outputs.

Only the bench's scenarios can show the rest: which side wins in select order, address order and a tie, and that the grant holds and then passes on. They also show that discarded writes leave the old word in place, that partial byte writes merge, and that slave-mode inhibit and read-before-write hold. The bench shows each of these by writing words and reading them back later.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    GR_NONE  = 2'd0,
    GR_LEFT  = 2'd1,
    GR_RIGHT = 2'd2
  } grant_e;
endpackage

// File: rtl/scr_arbiter.sv
module scr_arbiter
  import scr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master,
  input  logic              act_l,
  input  logic              act_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              lose_l,
  output logic              lose_r
);
  logic              prev_act_l, prev_act_r;
  logic [ADDR_W-1:0] prev_addr_l, prev_addr_r;
  grant_e            owner_q, win;
  logic              same_word, settled_l, settled_r;

  always_comb begin
    same_word = act_l && act_r && (addr_l == addr_r);
    // a side is "earlier" if it was selected at this very address last cycle
    settled_l = act_l && prev_act_l && (addr_l == prev_addr_l);
    settled_r = act_r && prev_act_r && (addr_r == prev_addr_r);
    win = GR_NONE;
    if (master && same_word) begin
      if (owner_q != GR_NONE && settled_l && settled_r) win = owner_q;
      else if (settled_r && !settled_l)                 win = GR_RIGHT;
      else                                              win = GR_LEFT;
    end
  end

  assign lose_l = (win == GR_RIGHT);
  assign lose_r = (win == GR_LEFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_act_l  <= 1'b0;
      prev_act_r  <= 1'b0;
      prev_addr_l <= '0;
      prev_addr_r <= '0;
      owner_q     <= GR_NONE;
    end else begin
      prev_act_l  <= act_l;
      prev_act_r  <= act_r;
      prev_addr_l <= addr_l;
      prev_addr_r <= addr_r;
      owner_q     <= win;
    end
  end
endmodule

// File: rtl/scr_port_ctl.sv
module scr_port_ctl #(
  parameter int LANES = 2
) (
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  input  logic             lose,
  input  logic             master,
  input  logic             busy_in_n,
  output logic             act,
  output logic [LANES-1:0] wr_be,
  output logic             rd_go,
  output logic [LANES-1:0] rd_be
);
  logic wr_ok;

  always_comb begin
    act   = !cs_n;
    wr_ok = act && !we_n && !lose && (master || busy_in_n);
    wr_be = wr_ok ? ~be_n : '0;
    rd_go = act && we_n && !oe_n && !lose;
    rd_be = ~be_n;
  end
endmodule

// File: rtl/scr_mem.sv
module scr_mem #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                          clk,
  input  logic [ADDR_W-1:0]             addr_a,
  input  logic [LANES-1:0]              be_a,
  input  logic [LANES-1:0][LANE_W-1:0]  wd_a,
  output logic [LANES-1:0][LANE_W-1:0]  q_a,
  input  logic [ADDR_W-1:0]             addr_b,
  input  logic [LANES-1:0]              be_b,
  input  logic [LANES-1:0][LANE_W-1:0]  wd_b,
  output logic [LANES-1:0][LANE_W-1:0]  q_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

  // read-first on both ports; port A is applied last on a same-lane clash
  always_ff @(posedge clk) begin
    q_a <= mem[addr_a];
    q_b <= mem[addr_b];
    for (int i = 0; i < LANES; i++) begin
      if (be_b[i]) mem[addr_b][i] <= wd_b[i];
      if (be_a[i]) mem[addr_a][i] <= wd_a[i];
    end
  end
endmodule

// File: rtl/shared_ram_contend.sv
module shared_ram_contend #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  master_strap,
  input  logic                  l_cs_n,
  input  logic                  l_we_n,
  input  logic                  l_oe_n,
  input  logic                  l_ub_n,
  input  logic                  l_lb_n,
  input  logic [ADDR_W-1:0]     l_addr,
  input  logic [2*LANE_W-1:0]   l_wdata,
  output logic [2*LANE_W-1:0]   l_rdata,
  input  logic                  l_busy_in_n,
  output logic                  l_busy_out_n,
  input  logic                  r_cs_n,
  input  logic                  r_we_n,
  input  logic                  r_oe_n,
  input  logic                  r_ub_n,
  input  logic                  r_lb_n,
  input  logic [ADDR_W-1:0]     r_addr,
  input  logic [2*LANE_W-1:0]   r_wdata,
  output logic [2*LANE_W-1:0]   r_rdata,
  input  logic                  r_busy_in_n,
  output logic                  r_busy_out_n
);
  localparam int LANES = 2;

  logic                         act_l, act_r, lose_l, lose_r;
  logic                         rd_go_l, rd_go_r;
  logic [LANES-1:0]             wr_be_l, wr_be_r, rd_be_l, rd_be_r;
  logic [LANES-1:0][LANE_W-1:0] wd_l, wd_r, q_l, q_r;
  logic                         rdv_l, rdv_r, busy_l_q, busy_r_q;
  logic [LANES-1:0]             rmask_l, rmask_r;

  assign wd_l = l_wdata;
  assign wd_r = r_wdata;

  scr_port_ctl #(.LANES(LANES)) u_ctl_l (
    .cs_n(l_cs_n), .we_n(l_we_n), .oe_n(l_oe_n), .be_n({l_ub_n, l_lb_n}),
    .lose(lose_l), .master(master_strap), .busy_in_n(l_busy_in_n),
    .act(act_l), .wr_be(wr_be_l), .rd_go(rd_go_l), .rd_be(rd_be_l)
  );

  scr_port_ctl #(.LANES(LANES)) u_ctl_r (
    .cs_n(r_cs_n), .we_n(r_we_n), .oe_n(r_oe_n), .be_n({r_ub_n, r_lb_n}),
    .lose(lose_r), .master(master_strap), .busy_in_n(r_busy_in_n),
    .act(act_r), .wr_be(wr_be_r), .rd_go(rd_go_r), .rd_be(rd_be_r)
  );

  scr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst(rst), .master(master_strap),
    .act_l(act_l), .act_r(act_r), .addr_l(l_addr), .addr_r(r_addr),
    .lose_l(lose_l), .lose_r(lose_r)
  );

  scr_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk),
    .addr_a(l_addr), .be_a(wr_be_l), .wd_a(wd_l), .q_a(q_l),
    .addr_b(r_addr), .be_b(wr_be_r), .wd_b(wd_r), .q_b(q_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_l_q <= 1'b1;
      busy_r_q <= 1'b1;
      rdv_l    <= 1'b0;
      rdv_r    <= 1'b0;
      rmask_l  <= '0;
      rmask_r  <= '0;
    end else begin
      busy_l_q <= !(master_strap && lose_l);
      busy_r_q <= !(master_strap && lose_r);
      rdv_l    <= rd_go_l;
      rdv_r    <= rd_go_r;
      rmask_l  <= rd_be_l;
      rmask_r  <= rd_be_r;
    end
  end

  assign l_busy_out_n = busy_l_q;
  assign r_busy_out_n = busy_r_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign l_rdata[g*LANE_W +: LANE_W] = (rdv_l && rmask_l[g]) ? q_l[g] : '0;
    assign r_rdata[g*LANE_W +: LANE_W] = (rdv_r && rmask_r[g]) ? q_r[g] : '0;
  end
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                master_strap,
  input logic                l_cs_n,
  input logic                l_oe_n,
  input logic [ADDR_W-1:0]   l_addr,
  input logic [2*LANE_W-1:0] l_rdata,
  input logic                l_busy_out_n,
  input logic                r_cs_n,
  input logic                r_oe_n,
  input logic [ADDR_W-1:0]   r_addr,
  input logic [2*LANE_W-1:0] r_rdata,
  input logic                r_busy_out_n
);
  AST_FREE_PATH: assert property (@(posedge clk) disable iff (rst)
    (master_strap && !(!l_cs_n && !r_cs_n && l_addr == r_addr)) |=> (l_busy_out_n && r_busy_out_n)); // R1
  AST_OE_IDLE_L: assert property (@(posedge clk) disable iff (rst)
    l_oe_n |=> (l_rdata == '0)); // R3
  AST_OE_IDLE_R: assert property (@(posedge clk) disable iff (rst)
    r_oe_n |=> (r_rdata == '0)); // R3
  AST_SINGLE_LOSER: assert property (@(posedge clk) disable iff (rst)
    (l_busy_out_n || r_busy_out_n)); // R7
  AST_LOSER_DARK_L: assert property (@(posedge clk) disable iff (rst)
    !l_busy_out_n |-> (l_rdata == '0)); // R7
  AST_LOSER_DARK_R: assert property (@(posedge clk) disable iff (rst)
    !r_busy_out_n |-> (r_rdata == '0)); // R7
  AST_DESEL_L: assert property (@(posedge clk) disable iff (rst)
    l_cs_n |=> l_busy_out_n); // R9
  AST_DESEL_R: assert property (@(posedge clk) disable iff (rst)
    r_cs_n |=> r_busy_out_n); // R9
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !master_strap |=> (l_busy_out_n && r_busy_out_n)); // R10
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (l_busy_out_n && r_busy_out_n && l_rdata == '0 && r_rdata == '0)); // R12
endmodule

bind shared_ram_contend scr_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .master_strap(master_strap),
  .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_rdata(l_rdata),
  .l_busy_out_n(l_busy_out_n),
  .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_rdata(r_rdata),
  .r_busy_out_n(r_busy_out_n)
);

// File: tb/sim_shared_ram_contend.sv
module sim_shared_ram_contend;
  localparam int CLK_P = 10;
  localparam int AW    = 10;
  localparam int NV    = 28;

  typedef struct packed {
    logic cs_n, we_n, oe_n, ub_n, lb_n;
    logic [AW-1:0] addr;
    logic [15:0]   wd;
  } pin_t;

  typedef struct packed {
    logic ms;
    pin_t l;
    pin_t r;
    logic bin_l, bin_r;
    logic ebl, ebr;
    logic [15:0] erl, err;
  } vec_t;

  // ben: bit1 = high-byte enable_n, bit0 = low-byte enable_n
  function automatic pin_t pw(int a, int d, int ben);
    pin_t p; p.cs_n = 0; p.we_n = 0; p.oe_n = 1; p.ub_n = ben[1]; p.lb_n = ben[0];
    p.addr = a[AW-1:0]; p.wd = d[15:0]; return p;
  endfunction
  function automatic pin_t pr(int a, int ben);
    pin_t p; p.cs_n = 0; p.we_n = 1; p.oe_n = 0; p.ub_n = ben[1]; p.lb_n = ben[0];
    p.addr = a[AW-1:0]; p.wd = 16'h0; return p;
  endfunction
  function automatic pin_t pn(int a);
    pin_t p; p.cs_n = 0; p.we_n = 1; p.oe_n = 1; p.ub_n = 0; p.lb_n = 0;
    p.addr = a[AW-1:0]; p.wd = 16'h0; return p;
  endfunction
  function automatic pin_t pq(int a);
    pin_t p; p.cs_n = 1; p.we_n = 1; p.oe_n = 1; p.ub_n = 1; p.lb_n = 1;
    p.addr = a[AW-1:0]; p.wd = 16'h0; return p;
  endfunction
  function automatic pin_t pwx(int a, int d);
    pin_t p; p.cs_n = 1; p.we_n = 0; p.oe_n = 1; p.ub_n = 0; p.lb_n = 0;
    p.addr = a[AW-1:0]; p.wd = d[15:0]; return p;
  endfunction
  function automatic vec_t v(int ms, pin_t l, pin_t r, int bl, int br,
                             int ebl, int ebr, int erl, int err);
    vec_t x; x.ms = ms[0]; x.l = l; x.r = r; x.bin_l = bl[0]; x.bin_r = br[0];
    x.ebl = ebl[0]; x.ebr = ebr[0]; x.erl = erl[15:0]; x.err = err[15:0]; return x;
  endfunction

  localparam vec_t VT [NV] = '{
    v(1, pw(5, 16'h1234, 0), pq(0),              1, 1, 1, 1, 0, 0),
    v(1, pq(0), pw(6, 16'hABCD, 0),              1, 1, 1, 1, 0, 0),
    v(1, pr(6, 0), pr(5, 0),                     1, 1, 1, 1, 16'hABCD, 16'h1234),
    v(1, pw(5, 16'hFF99, 1), pq(0),              1, 1, 1, 1, 0, 0),
    v(1, pq(0), pr(5, 2),                        1, 1, 1, 1, 0, 16'h0034),
    v(1, pr(5, 1), pq(0),                        1, 1, 1, 1, 16'hFF00, 0),
    v(1, pn(5), pq(0),                           1, 1, 1, 1, 0, 0),
    v(1, pr(5, 0), pq(5),                        1, 1, 1, 1, 16'hFF34, 0),
    v(1, pr(5, 0), pw(5, 16'h0BAD, 0),           1, 1, 1, 0, 16'hFF34, 0),
    v(1, pr(5, 0), pw(5, 16'h0BAD, 0),           1, 1, 1, 0, 16'hFF34, 0),
    v(1, pq(5), pw(5, 16'h0BAD, 0),              1, 1, 1, 1, 0, 0),
    v(1, pr(5, 0), pq(0),                        1, 1, 1, 1, 16'h0BAD, 0),
    v(1, pq(6), pr(6, 0),                        1, 1, 1, 1, 0, 16'hABCD),
    v(1, pw(6, 16'h1111, 0), pr(6, 0),           1, 1, 0, 1, 0, 16'hABCD),
    v(1, pr(6, 0), pq(0),                        1, 1, 1, 1, 16'hABCD, 0),
    v(1, pr(5, 0), pr(6, 0),                     1, 1, 1, 1, 16'h0BAD, 16'hABCD),
    v(1, pr(6, 0), pr(6, 0),                     1, 1, 0, 1, 0, 16'hABCD),
    v(1, pr(6, 0), pr(5, 0),                     1, 1, 1, 1, 16'hABCD, 16'h0BAD),
    v(1, pr(6, 0), pr(6, 0),                     1, 1, 1, 0, 16'hABCD, 0),
    v(1, pq(0), pq(0),                           1, 1, 1, 1, 0, 0),
    v(1, pr(5, 0), pr(5, 0),                     1, 1, 1, 0, 16'h0BAD, 0),
    v(1, pr(5, 0), pwx(5, 16'h7777),             1, 1, 1, 1, 16'h0BAD, 0),
    v(0, pw(5, 16'h2222, 0), pq(0),              0, 1, 1, 1, 0, 0),
    v(0, pr(5, 0), pq(0),                        0, 1, 1, 1, 16'h0BAD, 0),
    v(0, pw(5, 16'h3333, 0), pr(5, 0),           1, 0, 1, 1, 0, 16'h0BAD),
    v(0, pr(5, 0), pq(0),                        1, 1, 1, 1, 16'h3333, 0),
    v(1, pq(0), pw(7, 16'h4444, 0),              1, 0, 1, 1, 0, 0),
    v(1, pq(0), pr(7, 0),                        1, 0, 1, 1, 0, 16'h4444)
  };

  localparam string TAG [NV] = '{
    "R1", "R1", "R1", "R2", "R2", "R2", "R3", "R4", "R4", "R8",
    "R8", "R8", "R4", "R4", "R7", "R1", "R5", "R8", "R5", "R3",
    "R6", "R9", "R10", "R10", "R13", "R10", "R11", "R11"
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms;
  pin_t pl, prt;
  logic bin_l, bin_r;
  logic [15:0] l_rdata, r_rdata;
  logic l_busy_out_n, r_busy_out_n;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  shared_ram_contend #(.ADDR_W(AW), .LANE_W(8)) u0 (
    .clk(clk), .rst(rst), .master_strap(ms),
    .l_cs_n(pl.cs_n), .l_we_n(pl.we_n), .l_oe_n(pl.oe_n), .l_ub_n(pl.ub_n),
    .l_lb_n(pl.lb_n), .l_addr(pl.addr), .l_wdata(pl.wd), .l_rdata(l_rdata),
    .l_busy_in_n(bin_l), .l_busy_out_n(l_busy_out_n),
    .r_cs_n(prt.cs_n), .r_we_n(prt.we_n), .r_oe_n(prt.oe_n), .r_ub_n(prt.ub_n),
    .r_lb_n(prt.lb_n), .r_addr(prt.addr), .r_wdata(prt.wd), .r_rdata(r_rdata),
    .r_busy_in_n(bin_r), .r_busy_out_n(r_busy_out_n)
  );

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    ms = 1'b1; pl = pq(0); prt = pq(0); bin_l = 1'b1; bin_r = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "reset l_busy", {15'b0, l_busy_out_n}, 16'h1);
    chk("R12", "reset r_busy", {15'b0, r_busy_out_n}, 16'h1);
    chk("R12", "reset l_rdata", l_rdata, 16'h0);
    chk("R12", "reset r_rdata", r_rdata, 16'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      ms = VT[i].ms; pl = VT[i].l; prt = VT[i].r;
      bin_l = VT[i].bin_l; bin_r = VT[i].bin_r;
      @(negedge clk);
      chk(TAG[i], $sformatf("vec %0d l_busy", i), {15'b0, l_busy_out_n}, {15'b0, VT[i].ebl});
      chk(TAG[i], $sformatf("vec %0d r_busy", i), {15'b0, r_busy_out_n}, {15'b0, VT[i].ebr});
      chk(TAG[i], $sformatf("vec %0d l_rdata", i), l_rdata, VT[i].erl);
      chk(TAG[i], $sformatf("vec %0d r_rdata", i), r_rdata, VT[i].err);
    end

    // reset in the middle of a held conflict clears busy and read data (R12)
    ms = 1'b1; bin_l = 1'b1; bin_r = 1'b1;
    pl = pr(6, 0); prt = pq(0);
    @(negedge clk);
    prt = pr(6, 0);
    @(negedge clk);
    chk("R4", "pre-reset r_busy", {15'b0, r_busy_out_n}, 16'h0);
    rst = 1'b1;
    @(negedge clk);
    chk("R12", "mid-conflict reset r_busy", {15'b0, r_busy_out_n}, 16'h1);
    chk("R12", "mid-conflict reset l_rdata", l_rdata, 16'h0);
    rst = 1'b0;
    pl = pq(0); prt = pq(0);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule